// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Flash Invalidate

This block sits between a 32-bit instruction fetch stage and a pipelined memory bus. Each row of its data array is 64 bits wide and holds two instructions, so one array read can serve two consecutive fetches. A fetch presents a word address, a request strobe and a flag saying the address follows the previous one by 4. On a hit, the instruction appears one cycle later. On a miss, the fetch is stalled. The cache then refills the whole 64-byte line, eight doublewords, over the bus. After the refill ends, the stalled fetch is replayed.

A one-cycle flash-invalidate input clears every valid bit at once. There are two hazards around that pulse. First, a sequential fetch of the upper word is served from the doubleword already read in the previous cycle. It is never reported as a miss, so an instruction cannot be delivered twice. Second, a refill interrupted by the pulse stops issuing reads and waits for the outstanding acknowledgements. It then returns to idle without ever marking its line valid.

Back-pressure rules: `fetch_req` acts as a valid signal and `fetch_stall` as not-ready. While stalled, the fetch stage holds `fetch_addr` and `fetch_seq` steady, and the request is accepted on the first edge where the stall is low. On the bus, a read is accepted on an edge where `wb_stb` is high and `wb_stall` is low. While it is stalled, the cache holds `wb_adr`.

Top module: `icache_flash`

## Requirements
- R1: After reset, no line is valid, and `fetch_stall`, `insn_valid`, `wb_cyc` and `wb_stb` are all low.
- R2: A request to a valid line is accepted with `fetch_stall` low. In the next cycle `insn_valid` is high, and `insn` is the upper half (bits 63:32) of the addressed doubleword when address bit 2 is 1, or the lower half (bits 31:0) when it is 0.
- R3: A request to an absent line holds `fetch_stall` high until the refill ends. The refill issues exactly eight reads, at line base + 8·k for k = 0..7 in that order. The replayed request then delivers the newly loaded instruction.
- R4: `wb_stb` is only high together with `wb_cyc`. A refill never issues more than eight reads, and `wb_cyc` stays high until every issued read has been acknowledged.
- R5: A request with `fetch_seq` high and address bit 2 set, whose previous cycle delivered an instruction, is served from the held doubleword. It sees no stall and causes no bus read.
- R6: The rule of R5 holds even when a flash invalidate in the previous cycle cleared that line. Such a request is never stalled and is delivered exactly once.
- R7: A flash-invalidate pulse clears all valid bits. Later requests to any earlier cached line miss and reload from memory.
- R8: A flash invalidate during a refill stops new reads and drains the outstanding acknowledgements. The line stays invalid, also when the pulse coincides with the final acknowledgement. The replayed fetch misses and starts a new refill.
- R9: Mapping is direct. Address bits 8:6 select the line and bits 31:9 form the tag, so two addresses with equal index and different tags evict each other.
- R10: While `wb_stall` holds a read back, `wb_stb` stays high and `wb_adr` stays unchanged, unless a flash invalidate aborts the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request valid |
| fetch_addr | input | 30 | Instruction word address (byte address bits 31:2) |
| fetch_seq | input | 1 | Address equals previous address plus 4 |
| fetch_stall | output | 1 | Request not accepted this cycle; hold it |
| insn_valid | output | 1 | Instruction for the request accepted last cycle |
| insn | output | 32 | Delivered instruction |
| flash_inv | input | 1 | One-cycle pulse clearing all valid bits |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Read request strobe |
| wb_adr | output | 32 | Doubleword-aligned read byte address |
| wb_ack | input | 1 | Read data acknowledge |
| wb_dat | input | 64 | Read data |
| wb_stall | input | 1 | Bus cannot accept a request this cycle |

## Verification
The hardest cases to reach are the two invalidate races. Each needs the pulse to land in one exact cycle relative to the fetch or the bus. For the held-word case, the driver raises the invalidate in the same cycle it presents a lower-word hit, then follows at once with the sequential upper-word fetch. For the abort case, a second branch of the stimulus watches the count of accepted bus reads and fires the pulse partway through the refill. The bench then checks that the replayed fetch triggers a fresh refill and returns correct data. A periodic bus stall runs throughout, so back-pressure meets every refill.

// File: rtl/icache_flash_pkg.sv
package icache_flash_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,   // no refill in progress
    ST_SETUP,  // write new tag, drop line valid
    ST_FILL,   // issue reads, collect data
    ST_DRAIN   // aborted: wait for outstanding acks only
  } refill_st_t;
endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3,
  parameter int TAG_W     = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             flash,
  input  logic             tag_we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             set_valid
);
  logic [NUM_LINES-1:0] valid;
  logic [TAG_W-1:0]     tags [NUM_LINES];

  always_ff @(posedge clk) begin
    if (tag_we) tags[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
    end else if (flash) begin
      valid <= '0;                      // flash wins over any completion
    end else begin
      if (tag_we)    valid[wr_idx] <= 1'b0;
      if (set_valid) valid[wr_idx] <= 1'b1;
    end
  end

  assign lk_hit = valid[lk_idx] && (tags[lk_idx] == lk_tag);

  // R7
  flash_clears_all_chk: assert property (@(posedge clk) disable iff (rst)
    flash |=> (valid == '0));

  // R8
  no_valid_on_flash_chk: assert property (@(posedge clk) disable iff (rst)
    (flash && set_valid) |=> (valid == '0));
endmodule

// File: rtl/icache_refill.sv
module icache_refill
  import icache_flash_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LINE_DW = 8,
  parameter int IDX_W   = 3,
  parameter int TAG_W   = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TAG_W-1:0]  start_tag,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              flash,
  output logic              busy,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic [ADDR_W-1:0] wb_adr,
  input  logic              wb_ack,
  input  logic              wb_stall,
  output logic              tag_we,
  output logic [TAG_W-1:0]  line_tag,
  output logic [IDX_W-1:0]  line_idx,
  output logic              set_valid,
  output logic              fill_we,
  output logic [IDX_W+$clog2(LINE_DW)-1:0] fill_row
);
  localparam int DW_W  = $clog2(LINE_DW);
  localparam int CNT_W = DW_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LINE_DW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_DW - 1);

  refill_st_t       state;
  logic [CNT_W-1:0] req_cnt, ack_cnt, ack_nxt;
  logic             issue;

  assign ack_nxt  = ack_cnt + CNT_W'(wb_ack);
  assign busy     = (state != ST_IDLE);
  assign wb_stb   = (state == ST_FILL) && (req_cnt != FULL);
  assign wb_cyc   = (state == ST_FILL) || ((state == ST_DRAIN) && (ack_cnt != req_cnt));
  assign wb_adr   = {line_tag, line_idx, req_cnt[DW_W-1:0], 3'b000};
  assign issue    = wb_stb && !wb_stall;
  assign tag_we   = (state == ST_SETUP);
  assign fill_we  = wb_ack && ((state == ST_FILL) || (state == ST_DRAIN));
  assign fill_row = {line_idx, ack_cnt[DW_W-1:0]};
  assign set_valid = (state == ST_FILL) && wb_ack && (ack_cnt == LAST) && !flash;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      req_cnt  <= '0;
      ack_cnt  <= '0;
      line_tag <= '0;
      line_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          line_tag <= start_tag;
          line_idx <= start_idx;
          state    <= ST_SETUP;
        end
        ST_SETUP: begin
          req_cnt <= '0;
          ack_cnt <= '0;
          state   <= flash ? ST_DRAIN : ST_FILL;
        end
        ST_FILL: begin
          if (issue)  req_cnt <= req_cnt + 1'b1;
          if (wb_ack) ack_cnt <= ack_nxt;
          if (flash)                          state <= ST_DRAIN;
          else if (wb_ack && ack_cnt == LAST) state <= ST_IDLE;
        end
        ST_DRAIN: begin
          if (wb_ack) ack_cnt <= ack_nxt;
          if (ack_nxt == req_cnt) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  stb_needs_cyc_chk: assert property (@(posedge clk) disable iff (rst)
    wb_stb |-> wb_cyc);
  // R4
  issue_bound_chk: assert property (@(posedge clk) disable iff (rst)
    req_cnt <= FULL);
  // R4
  cyc_until_drained_chk: assert property (@(posedge clk) disable iff (rst)
    !wb_cyc |-> (req_cnt == ack_cnt));
  // R8
  abort_stops_reads_chk: assert property (@(posedge clk) disable iff (rst)
    (flash && busy) |=> !wb_stb);
  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && wb_stall && !flash) |=> (wb_stb && $stable(wb_adr)));
endmodule

// File: rtl/icache_data.sv
module icache_data #(
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [63:0]      wr_data,
  input  logic             rd_en,
  input  logic [ROW_W-1:0] rd_row,
  output logic [63:0]      rd_q
);
  localparam int ROWS = 1 << ROW_W;
  logic [63:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[wr_row] <= wr_data;
  end

  // read register holds its value when no read is requested
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_row];
  end
endmodule

// File: rtl/icache_flash.sv
module icache_flash #(
  parameter int ADDR_W    = 32,
  parameter int LINE_DW   = 8,
  parameter int NUM_LINES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:2] fetch_addr,
  input  logic              fetch_seq,
  output logic              fetch_stall,
  output logic              insn_valid,
  output logic [31:0]       insn,
  input  logic              flash_inv,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic [ADDR_W-1:0] wb_adr,
  input  logic              wb_ack,
  input  logic [63:0]       wb_dat,
  input  logic              wb_stall
);
  localparam int DW_W  = $clog2(LINE_DW);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - 3 - DW_W - IDX_W;
  localparam int ROW_W = IDX_W + DW_W;

  logic [DW_W-1:0]  req_dw;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic             hit, busy, use_prev, take, start;
  logic             prev_ok, out_hi;
  logic             tag_we, set_valid, fill_we;
  logic [TAG_W-1:0] line_tag;
  logic [IDX_W-1:0] line_idx;
  logic [ROW_W-1:0] fill_row;
  logic [63:0]      rd_q;

  assign req_dw  = fetch_addr[3+DW_W-1:3];
  assign req_idx = fetch_addr[3+DW_W+IDX_W-1:3+DW_W];
  assign req_tag = fetch_addr[ADDR_W-1:ADDR_W-TAG_W];

  // second word of the held doubleword: never a miss, never a stall
  assign use_prev    = fetch_req && fetch_seq && fetch_addr[2] && prev_ok;
  assign fetch_stall = fetch_req && !use_prev && (!hit || busy);
  assign take        = fetch_req && !fetch_stall;
  assign start       = fetch_stall && !busy;

  icache_tags #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .lk_idx(req_idx), .lk_tag(req_tag), .lk_hit(hit),
    .flash(flash_inv), .tag_we(tag_we), .wr_idx(line_idx), .wr_tag(line_tag),
    .set_valid(set_valid)
  );

  icache_refill #(.ADDR_W(ADDR_W), .LINE_DW(LINE_DW), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_refill (
    .clk(clk), .rst(rst), .start(start), .start_tag(req_tag), .start_idx(req_idx),
    .flash(flash_inv), .busy(busy), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_adr(wb_adr),
    .wb_ack(wb_ack), .wb_stall(wb_stall), .tag_we(tag_we), .line_tag(line_tag),
    .line_idx(line_idx), .set_valid(set_valid), .fill_we(fill_we), .fill_row(fill_row)
  );

  icache_data #(.ROW_W(ROW_W)) u_data (
    .clk(clk), .we(fill_we), .wr_row(fill_row), .wr_data(wb_dat),
    .rd_en(fetch_req && !use_prev), .rd_row({req_idx, req_dw}), .rd_q(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ok    <= 1'b0;
      insn_valid <= 1'b0;
      out_hi     <= 1'b0;
    end else begin
      prev_ok    <= take;
      insn_valid <= take;
      out_hi     <= fetch_addr[2];
    end
  end

  assign insn = out_hi ? rd_q[63:32] : rd_q[31:0];

  // R2
  deliver_next_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> insn_valid);
  // R3
  miss_starts_refill_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_stall && !busy) |=> busy);
  // R6
  held_word_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_seq && fetch_addr[2] && $past(take)) |-> !fetch_stall);
endmodule

// File: tb/icache_flash_test.sv
module icache_flash_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req = 1'b0, fetch_seq = 1'b0, flash_inv = 1'b0;
  logic [31:2] fetch_addr = '0;
  logic        fetch_stall, insn_valid, wb_cyc, wb_stb, wb_ack, wb_stall;
  logic [31:0] insn, wb_adr;
  logic [63:0] wb_dat;

  int checks = 0, errors = 0;
  int req_total = 0, stall_hits = 0, cyc_n = 0;
  logic [31:0] adr_log [16];
  logic [7:0]  gen = 8'd1;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        p1v = 0, p2v = 0;
  logic [31:0] p1a = '0, p2a = '0;

  always #10 clk = ~clk;  // 50 MHz

  icache_flash uut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_seq(fetch_seq), .fetch_stall(fetch_stall), .insn_valid(insn_valid),
    .insn(insn), .flash_inv(flash_inv), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
    .wb_adr(wb_adr), .wb_ack(wb_ack), .wb_dat(wb_dat), .wb_stall(wb_stall)
  );

  function automatic logic [31:0] word_of(logic [31:0] a);
    return {gen, a[23:2], 2'b01};
  endfunction

  // memory model: two-cycle read latency, stall every third cycle
  assign wb_stall = (cyc_n % 3 == 2);
  assign wb_ack   = p2v;
  assign wb_dat   = {word_of({p2a[31:3], 3'b100}), word_of({p2a[31:3], 3'b000})};

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    p1v <= wb_stb && !wb_stall && wb_cyc;
    p1a <= wb_adr;
    p2v <= p1v;
    p2a <= p1a;
    if (wb_stb && wb_stall) stall_hits <= stall_hits + 1;
    if (wb_stb && !wb_stall) begin
      if (req_total < 16) adr_log[req_total] <= wb_adr;
      req_total <= req_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop one expected word per delivered instruction
  always @(negedge clk) begin
    if (!rst && insn_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 extra delivery", insn, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(insn == e, t, insn, e);
      end
    end
  end

  task automatic do_fetch(input logic [31:0] a, input bit seq, input bit fl,
                          input string req, output int stalls);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a[31:2]; fetch_seq = seq; flash_inv = fl;
    exp_q.push_back(word_of(a)); tag_q.push_back(req);
    #1;
    stalls = 0;
    while (fetch_stall) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    if (fl) flash_inv = 1'b0;
  endtask

  task automatic go_idle();
    @(negedge clk);
    fetch_req = 1'b0; fetch_seq = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 0);
    finish_run();
  end

  initial begin
    int st, base;
    localparam logic [31:0] A = 32'h0000_1040;  // index 1
    localparam logic [31:0] B = 32'h0000_1240;  // index 1, other tag
    localparam logic [31:0] C = 32'h0000_2080;  // index 2
    localparam logic [31:0] D = 32'h0000_30C0;  // index 3
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(!fetch_stall && !insn_valid && !wb_cyc && !wb_stb, "R1 idle outputs",
        {fetch_stall, insn_valid, wb_cyc, wb_stb}, 0);

    // R3 cold miss with stalled bus (R10)
    base = req_total;
    do_fetch(A, 0, 0, "R3 R10 refill data", st);
    chk(st > 0, "R3 miss stalls", st, 1);
    go_idle();
    chk(req_total - base == 8, "R3 R4 eight reads", req_total - base, 8);
    for (int k = 0; k < 8; k++)
      chk(adr_log[k] == A + 32'(8 * k), "R3 read order", adr_log[k], A + 32'(8 * k));
    chk(stall_hits > 0, "R10 bus stall met", stall_hits, 1);

    // R2 hits, lower and upper half
    base = req_total;
    do_fetch(A + 32'h10, 0, 0, "R2 lower half", st);
    chk(st == 0, "R2 hit no stall", st, 0);
    // R5 sequential upper word from held doubleword
    do_fetch(A + 32'h14, 1, 0, "R5 held word", st);
    chk(st == 0, "R5 no stall", st, 0);
    do_fetch(A + 32'h3C, 0, 0, "R2 upper half", st);
    chk(st == 0, "R2 upper hit", st, 0);
    go_idle();
    chk(req_total == base, "R5 no bus read", req_total - base, 0);

    // R9 conflict in one index
    do_fetch(B, 0, 0, "R9 conflict data", st);
    chk(st > 0, "R9 evicting miss", st, 1);
    do_fetch(A, 0, 0, "R9 evicted reload", st);
    chk(st > 0, "R9 evicted line misses", st, 1);
    do_fetch(C, 0, 0, "R3 second line", st);
    do_fetch(C + 32'h8, 0, 0, "R2 second line hit", st);
    chk(st == 0, "R2 second line no stall", st, 0);
    go_idle();

    // R7 flash clears everything; memory content changes
    @(negedge clk); flash_inv = 1'b1;
    @(negedge clk); flash_inv = 1'b0;
    gen = 8'd2;
    do_fetch(A, 0, 0, "R7 new data A", st);
    chk(st > 0, "R7 A misses", st, 1);
    do_fetch(C, 0, 0, "R7 new data C", st);
    chk(st > 0, "R7 C misses", st, 1);
    go_idle();

    // R6 flash in the cycle of a lower-word hit, then sequential upper word
    base = req_total;
    do_fetch(C + 32'h20, 0, 1, "R6 lower word", st);
    chk(st == 0, "R6 lower hit", st, 0);
    do_fetch(C + 32'h24, 1, 0, "R6 upper once", st);
    chk(st == 0, "R6 no stall after flash", st, 0);
    go_idle();
    chk(req_total == base, "R6 no refill", req_total - base, 0);
    chk(exp_q.size() == 0, "R6 single delivery", exp_q.size(), 0);
    do_fetch(C + 32'h20, 0, 0, "R7 invalid after flash", st);
    chk(st > 0, "R7 line now misses", st, 1);
    go_idle();

    // R8 flash in the middle of a refill
    gen = 8'd3;
    base = req_total;
    fork
      do_fetch(D, 0, 0, "R8 data after abort", st);
      begin
        while (req_total < base + 3) @(negedge clk);
        flash_inv = 1'b1;
        @(negedge clk);
        flash_inv = 1'b0;
      end
    join
    go_idle();
    chk(req_total - base > 8, "R8 refill restarted", req_total - base, 9);
    chk(req_total - base <= 16, "R4 read bound", req_total - base, 16);
    chk(!wb_cyc && !p1v && !p2v, "R4 R8 drained", {wb_cyc, p1v, p2v}, 0);
    do_fetch(D + 32'h8, 0, 0, "R8 line valid after redo", st);
    chk(st == 0, "R8 redo hit", st, 0);
    go_idle();
    chk(exp_q.size() == 0, "R2 all delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule